// File: doc/BRIEF.md
# Per-Warp Bounded Dependency Scoreboard

This block tracks register writes that are still in flight for every warp of a multithreaded core. Instead of one busy bit per architectural register, each warp owns a few entries. Each entry holds the ID of a register that an issued instruction will write. The number of occupied entries is the warp's count of pending writes.

When the front end places an instruction in a buffer slot, the block compares the instruction's two source IDs and its destination ID against every occupied entry of the same warp at once. Each entry yields one bit of a dependency mask, and the block keeps that mask beside the slot. A slot may issue only when its mask is zero. If the instruction writes a register, its warp must also have a free entry. On issue, the destination is written into the lowest free entry, and that entry's index is handed out as a tag. When the execution side returns the tag, the entry is freed and the matching mask bit is cleared in every buffered slot of that warp.

The block holds only each slot's mask, warp, destination and valid bit. The instruction words and the execution units are outside it.

Top module: `warp_dep_scoreboard`

## Requirements
- R1: After reset no slot is valid, every `slot_ready` bit is 0, every mask bit is 0 and every per-warp count is 0.
- R2: An insert into slot s sets bit e of that slot's mask (field `slot_mask[s*ENTRIES+e]`) exactly when entry e of the same warp is occupied and holds a register equal to source A, source B, or (when `ins_has_dst` is 1) the destination. The comparison uses the entry state after that cycle's completion and issue have been applied.
- R3: `slot_ready[s]` is 1 exactly when slot s is valid, its mask is zero, and either it has no destination or its warp has a free entry. An entry freed by a completion in the same cycle counts as free.
- R4: An issue request for a slot whose `slot_ready` bit is 0 has no effect: `iss_ok` is 0, the slot stays valid and no count changes.
- R5: An accepted issue (`iss_ok`=1) frees the slot. If the slot has a destination, the lowest-index free entry of its warp receives it, `iss_entry` reports that index, and the warp's count rises by one.
- R6: A completion naming warp w and entry e frees that entry and clears mask bit e in every valid slot of warp w, both visible after the next clock edge.
- R7: A completion naming an unoccupied entry leaves every count and mask unchanged.
- R8: When all entries of a warp are occupied, a slot of that warp with a destination is not ready, while a slot without a destination and with a zero mask is ready.
- R9: An issue and a completion for the same warp in the same cycle both take effect, and the issue may be given the entry that the completion frees.
- R10: Entries of one warp never set mask bits in a slot that belongs to another warp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Place a new instruction in a slot |
| ins_slot | input | SL_W | Slot to fill |
| ins_warp | input | WP_W | Warp of the new instruction |
| ins_src_a | input | RID_W | First source register ID |
| ins_src_b | input | RID_W | Second source register ID |
| ins_dst | input | RID_W | Destination register ID |
| ins_has_dst | input | 1 | Instruction writes a register |
| iss_valid | input | 1 | Request issue of a slot |
| iss_slot | input | SL_W | Slot to issue |
| cmp_valid | input | 1 | A write has completed |
| cmp_warp | input | WP_W | Warp of the completed write |
| cmp_entry | input | EN_W | Entry index handed out at issue |
| slot_ready | output | SLOTS | Per-slot issue eligibility |
| slot_mask | output | SLOTS*ENTRIES | Per-slot dependency masks, slot s at bits s*ENTRIES upward |
| pend_cnt | output | WARPS*CN_W | Occupied entries per warp |
| iss_ok | output | 1 | Issue request accepted this cycle |
| iss_entry | output | EN_W | Entry allocated to the issuing instruction |

## Verification
The hardest situation to reach from the ports is a warp whose entries are all occupied while a completion for that same warp arrives in the same cycle as an issue that needs an entry. That case requires R8 and R9 to hold together. The stimulus fills one warp by inserting and issuing four writers in turn. It then parks a reader that depends on one of those writers and a writer that is blocked only by capacity, and finally fires the completion and the issue together. A long pseudo-random phase follows, with register IDs restricted to four values so that matches are frequent. During that phase a bench model computes the expected mask, readiness, allocated entry and counts.

// File: rtl/warp_dep_scoreboard.sv
module warp_dep_scoreboard #(
  parameter int WARPS   = 4,
  parameter int ENTRIES = 4,
  parameter int SLOTS   = 6,
  parameter int RID_W   = 5,
  localparam int WP_W = (WARPS   > 1) ? $clog2(WARPS)   : 1,
  localparam int EN_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int SL_W = (SLOTS   > 1) ? $clog2(SLOTS)   : 1,
  localparam int CN_W = $clog2(ENTRIES + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ins_valid,
  input  logic [SL_W-1:0]          ins_slot,
  input  logic [WP_W-1:0]          ins_warp,
  input  logic [RID_W-1:0]         ins_src_a,
  input  logic [RID_W-1:0]         ins_src_b,
  input  logic [RID_W-1:0]         ins_dst,
  input  logic                     ins_has_dst,
  input  logic                     iss_valid,
  input  logic [SL_W-1:0]          iss_slot,
  input  logic                     cmp_valid,
  input  logic [WP_W-1:0]          cmp_warp,
  input  logic [EN_W-1:0]          cmp_entry,
  output logic [SLOTS-1:0]         slot_ready,
  output logic [SLOTS*ENTRIES-1:0] slot_mask,
  output logic [WARPS*CN_W-1:0]    pend_cnt,
  output logic                     iss_ok,
  output logic [EN_W-1:0]          iss_entry
);

  logic [ENTRIES-1:0] ev  [WARPS];
  logic [RID_W-1:0]   eid [WARPS][ENTRIES];
  logic [SLOTS-1:0]   sv, shd;
  logic [WP_W-1:0]    sw  [SLOTS];
  logic [RID_W-1:0]   sd  [SLOTS];
  logic [ENTRIES-1:0] sm  [SLOTS];

  logic [ENTRIES-1:0] evf [WARPS];
  logic [ENTRIES-1:0] ev_n [WARPS];
  logic [ENTRIES-1:0] cmp_hot, alloc_hot, ins_mask;
  logic [WP_W-1:0]    iw;
  logic [EN_W-1:0]    alloc;
  logic               iss_in, ins_in;

  assign iss_in  = {1'b0, iss_slot} < (SL_W+1)'(SLOTS);
  assign ins_in  = {1'b0, ins_slot} < (SL_W+1)'(SLOTS);
  assign cmp_hot = cmp_valid ? (ENTRIES'(1) << cmp_entry) : '0;
  assign iw      = iss_in ? sw[iss_slot] : '0;

  for (genvar w = 0; w < WARPS; w++) begin : g_warp
    assign evf[w]  = ev[w] & ~((cmp_warp == WP_W'(w)) ? cmp_hot : '0);
    assign ev_n[w] = evf[w] | ((iw == WP_W'(w)) ? alloc_hot : '0);
    assign pend_cnt[w*CN_W +: CN_W] = CN_W'($countones(ev[w]));
  end

  always_comb begin
    alloc = '0;
    for (int e = ENTRIES-1; e >= 0; e--)
      if (!evf[iw][e]) alloc = EN_W'(e);
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign slot_ready[s] = sv[s] && (sm[s] == '0) && (!shd[s] || !(&evf[sw[s]]));
    assign slot_mask[s*ENTRIES +: ENTRIES] = sm[s];
  end

  assign iss_ok    = iss_valid && iss_in && slot_ready[iss_slot];
  assign iss_entry = alloc;
  assign alloc_hot = (iss_ok && shd[iss_slot]) ? (ENTRIES'(1) << alloc) : '0;

  always_comb begin
    for (int e = 0; e < ENTRIES; e++) begin
      logic [RID_W-1:0] id;
      id = (alloc_hot[e] && iw == ins_warp) ? sd[iss_slot] : eid[ins_warp][e];
      ins_mask[e] = ev_n[ins_warp][e] &&
                    (id == ins_src_a || id == ins_src_b || (ins_has_dst && id == ins_dst));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sv <= '0;
      for (int w = 0; w < WARPS; w++) ev[w] <= '0;
      for (int s = 0; s < SLOTS; s++) sm[s] <= '0;
    end else begin
      for (int w = 0; w < WARPS; w++) ev[w] <= ev_n[w];
      if (alloc_hot != '0) eid[iw][alloc] <= sd[iss_slot];
      for (int s = 0; s < SLOTS; s++)
        sm[s] <= sm[s] & ~((sw[s] == cmp_warp) ? cmp_hot : '0);
      if (iss_ok) sv[iss_slot] <= 1'b0;
      if (ins_valid && ins_in) begin
        sv[ins_slot]  <= 1'b1;
        sw[ins_slot]  <= ins_warp;
        sd[ins_slot]  <= ins_dst;
        shd[ins_slot] <= ins_has_dst;
        sm[ins_slot]  <= ins_mask;
      end
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_chk
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      assert_mask_needs_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sv[s] && sm[s][e]) |-> ev[sw[s]][e]);
    end
    assert_cmp_clears_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid && !(alloc_hot != '0 && iw == cmp_warp) && !(ins_valid && ins_slot == SL_W'(s)))
      |=> !(sv[s] && sw[s] == $past(cmp_warp) && sm[s][$past(cmp_entry)]));
  end

  assert_issue_frees_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    iss_ok |=> (!sv[$past(iss_slot)] || $past(ins_valid && ins_slot == iss_slot)));

  assert_full_blocks_writer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_in && shd[iss_slot] && (&ev[iw]) && !(cmp_valid && cmp_warp == iw))
    |-> !iss_ok);

  assert_stale_cmp_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && !ev[cmp_warp][cmp_entry] && !iss_ok)
    |=> ev[$past(cmp_warp)] == $past(ev[cmp_warp]));

  assert_not_ready_refused_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_in && !slot_ready[iss_slot]) |-> !iss_ok);

endmodule

// File: tb/sim_warp_dep_scoreboard.sv
`timescale 1ns/1ps
module sim_warp_dep_scoreboard;
  localparam int W = 4, E = 4, S = 6, R = 5, WP = 2, EN = 2, SL = 3, CN = 3;

  logic clk = 0, rst_n = 0;
  logic ins_valid = 0, ins_has_dst = 0, iss_valid = 0, cmp_valid = 0;
  logic [SL-1:0] ins_slot = 0, iss_slot = 0;
  logic [WP-1:0] ins_warp = 0, cmp_warp = 0;
  logic [R-1:0]  ins_src_a = 0, ins_src_b = 0, ins_dst = 0;
  logic [EN-1:0] cmp_entry = 0;
  logic [S-1:0]  slot_ready;
  logic [S*E-1:0] slot_mask;
  logic [W*CN-1:0] pend_cnt;
  logic iss_ok;
  logic [EN-1:0] iss_entry;

  int checks = 0, failures = 0;
  bit done = 0;

  bit   mev [W][E];
  int   meid[W][E];
  bit   msv [S];
  int   msw [S], msd[S];
  bit   mshd[S];
  bit [E-1:0] msm[S];

  always #4 clk = ~clk;

  warp_dep_scoreboard #(.WARPS(W), .ENTRIES(E), .SLOTS(S), .RID_W(R)) u0 (
    .clk, .rst_n, .ins_valid, .ins_slot, .ins_warp, .ins_src_a, .ins_src_b,
    .ins_dst, .ins_has_dst, .iss_valid, .iss_slot, .cmp_valid, .cmp_warp,
    .cmp_entry, .slot_ready, .slot_mask, .pend_cnt, .iss_ok, .iss_entry);

  task automatic chk(input bit ok, input string what, input string tg,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tg, what, act, exp);
    end
  endtask

  task automatic step(input bit iv, input int is, input int iw, input int s0, input int s1,
                      input int d, input bit hd, input bit xv, input int xs,
                      input bit cv, input int cw, input int ce, input string tg);
    bit evf[W][E];
    bit [S-1:0] er;
    bit eok;
    int al, xw;
    logic [S*E-1:0] emask;
    logic [W*CN-1:0] ecnt;
    @(negedge clk);
    ins_valid = iv; ins_slot = SL'(is); ins_warp = WP'(iw); ins_src_a = R'(s0);
    ins_src_b = R'(s1); ins_dst = R'(d); ins_has_dst = hd;
    iss_valid = xv; iss_slot = SL'(xs);
    cmp_valid = cv; cmp_warp = WP'(cw); cmp_entry = EN'(ce);
    #1;
    for (int w = 0; w < W; w++)
      for (int e = 0; e < E; e++)
        evf[w][e] = mev[w][e] && !(cv && cw == w && ce == e);
    for (int s = 0; s < S; s++) begin
      bit fr = 0;
      for (int e = 0; e < E; e++) if (!evf[msw[s]][e]) fr = 1;
      er[s] = msv[s] && msm[s] == 0 && (!mshd[s] || fr);
    end
    chk(slot_ready === er, "slot_ready", tg, 64'(slot_ready), 64'(er));
    eok = xv && er[xs];
    chk(iss_ok === eok, "iss_ok", tg, 64'(iss_ok), 64'(eok));
    xw = msw[xs]; al = 0;
    for (int e = E-1; e >= 0; e--) if (!evf[xw][e]) al = e;
    if (eok && mshd[xs])
      chk(iss_entry === EN'(al), "iss_entry", tg, 64'(iss_entry), 64'(al));
    for (int w = 0; w < W; w++)
      for (int e = 0; e < E; e++) mev[w][e] = evf[w][e];
    if (eok && mshd[xs]) begin mev[xw][al] = 1; meid[xw][al] = msd[xs]; end
    for (int s = 0; s < S; s++) if (cv && msw[s] == cw) msm[s][ce] = 0;
    if (eok) msv[xs] = 0;
    if (iv) begin
      bit [E-1:0] m = '0;
      for (int e = 0; e < E; e++)
        m[e] = mev[iw][e] && (meid[iw][e] == s0 || meid[iw][e] == s1 || (hd && meid[iw][e] == d));
      msv[is] = 1; msw[is] = iw; msd[is] = d; mshd[is] = hd; msm[is] = m;
    end
    @(posedge clk); #1;
    for (int s = 0; s < S; s++) emask[s*E +: E] = msm[s];
    for (int w = 0; w < W; w++) begin
      int c = 0;
      for (int e = 0; e < E; e++) c += mev[w][e];
      ecnt[w*CN +: CN] = CN'(c);
    end
    chk(slot_mask === emask, "slot_mask", tg, 64'(slot_mask), 64'(emask));
    chk(pend_cnt === ecnt, "pend_cnt", tg, 64'(pend_cnt), 64'(ecnt));
  endtask

  task automatic idle(input string tg);
    step(0,0,0,0,0,0,0, 0,0, 0,0,0, tg);
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < W; w++) for (int e = 0; e < E; e++) begin mev[w][e] = 0; meid[w][e] = 0; end
    for (int s = 0; s < S; s++) begin msv[s] = 0; msw[s] = 0; msd[s] = 0; mshd[s] = 0; msm[s] = 0; end
    repeat (3) @(posedge clk);
    #1;
    chk(slot_ready === '0, "reset ready", "R1", 64'(slot_ready), 0);
    chk(slot_mask === '0, "reset mask", "R1", 64'(slot_mask), 0);
    chk(pend_cnt === '0, "reset count", "R1", 64'(pend_cnt), 0);
    @(negedge clk); rst_n = 1;

    // writer of r3 in warp 0, issued into entry 0
    step(1,0,0, 9,9,3,1, 0,0, 0,0,0, "R3");
    step(0,0,0, 0,0,0,0, 1,0, 0,0,0, "R5");
    // reader of r3 in warp 1 must not see warp 0 entries
    step(1,1,1, 3,3,7,1, 0,0, 0,0,0, "R10");
    // reader of r3 in warp 0 depends on entry 0
    step(1,2,0, 3,8,0,0, 0,0, 0,0,0, "R2");
    // issue request on the blocked slot is ignored
    step(0,0,0, 0,0,0,0, 1,2, 0,0,0, "R4");
    // completion of an empty entry in warp 3
    step(0,0,0, 0,0,0,0, 0,0, 1,3,2, "R7");
    // completion of entry 0 of warp 0 releases slot 2
    step(0,0,0, 0,0,0,0, 0,0, 1,0,0, "R6");
    step(0,0,0, 0,0,0,0, 1,2, 0,0,0, "R3");
    step(0,0,0, 0,0,0,0, 1,1, 0,0,0, "R5");

    // fill warp 2 with four writers
    for (int k = 0; k < E; k++) begin
      step(1,3,2, 20,21,10+k,1, 0,0, 0,0,0, "R5");
      step(0,0,0, 0,0,0,0, 1,3, 0,0,0, "R5");
    end
    // reader of r11 (entry 1), capacity-blocked writer, and a free reader
    step(1,3,2, 11,20,0,0, 0,0, 0,0,0, "R2");
    step(1,4,2, 20,21,15,1, 0,0, 0,0,0, "R8");
    step(1,5,2, 20,21,0,0, 0,0, 0,0,0, "R8");
    step(0,0,0, 0,0,0,0, 1,4, 0,0,0, "R8");
    step(0,0,0, 0,0,0,0, 1,5, 0,0,0, "R8");
    // completion of entry 1 and issue of the blocked writer in the same cycle
    step(0,0,0, 0,0,0,0, 1,4, 1,2,1, "R9");
    step(0,0,0, 0,0,0,0, 1,3, 0,0,0, "R9");
    for (int e = 0; e < E; e++) step(0,0,0, 0,0,0,0, 0,0, 1,2,e, "R6");
    idle("R6");

    // pseudo-random sweep with a narrow register range
    for (int n = 0; n < 4000; n++) begin
      int free_s = -1, is, iw, xs, cw, ce;
      bit iv, xv, cv;
      for (int s = 0; s < S; s++) if (!msv[s] && free_s < 0) free_s = s;
      iw = $urandom_range(W-1);
      iv = (free_s >= 0) && ($urandom_range(2) != 0);
      is = (free_s >= 0) ? free_s : 0;
      xs = $urandom_range(S-1);
      xv = $urandom_range(1);
      if (iv && xs == is) xv = 0;
      cv = $urandom_range(2) != 0;
      cw = $urandom_range(W-1);
      ce = $urandom_range(E-1);
      step(iv, is, iw, $urandom_range(3), $urandom_range(3), $urandom_range(3), $urandom_range(1),
           xv, xs, cv, cw, ce, "R2/R3/R5/R6/R9/R10");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule